// File: doc/BRIEF.md
# Complementary Deadtime Generator with Shutdown

This block turns a single switching command into two gate-enable signals for the upper and lower transistors of a half bridge. The upper enable follows the command and the lower enable follows its inverse. The two enables are never asserted in the same cycle. Whenever one side is released, the other side waits for a programmed gap before it is allowed to assert, and this gap applies in both directions. The gap is counted from the cycle in which one side starts to turn off to the cycle in which the other side starts to turn on.

A 3-bit mode input carries the output of an external multi-level comparison of a setting voltage. Four of its codes choose the gap length, from shortest to longest. All the other codes request shutdown, which holds both enables low. The switching input and the mode code are assumed to be synchronous to the block clock. At the default 5 ns tick the four gaps are 15, 25, 35 and 45 ns. Each gap length is a parameter in ticks.

Top module: `gate_pair_deadtime`

## Requirements
- R1: When an enable turns on, the upper enable `hiEn` asserts only for a high `swIn`, and the lower enable `loEn` asserts only for a low `swIn`.
- R2: `hiEn` and `loEn` are never both high in the same cycle.
- R3: With mode codes 0, 1, 2 and 3, the gap lasts `TICKS_DT0`, `TICKS_DT1`, `TICKS_DT2` and `TICKS_DT3` cycles respectively (defaults 3, 5, 7, 9). The gap runs from the first clock edge that samples a changed `swIn` and releases the active side, to the clock edge that asserts the other side. It applies to both the upper-to-lower and the lower-to-upper transition.
- R4: Mode codes 4 to 7 mean shutdown. In the cycle after such a code is sampled, both enables are low, and they stay low for as long as the code is present, whatever `swIn` does.
- R5: The gap length is fixed when a gap starts. A change of mode code among 0 to 3 during an on period or during a running gap has no effect until the next change of `swIn` starts a new gap.
- R6: After reset is released, or after a non-shutdown code replaces a shutdown code, both enables stay low for one full gap of the current mode. After that, the side selected by `swIn` turns on.
- R7: If `swIn` changes again before a gap has finished, the pending turn-on is cancelled. A new full gap then starts for the opposite side.
- R8: While `rstN` is low, both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, one tick per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| swIn | input | 1 | Switching command, high selects the upper side |
| modeCode | input | 3 | 0 to 3 select a gap preset, 4 to 7 request shutdown |
| hiEn | output | 1 | Upper gate enable |
| loEn | output | 1 | Lower gate enable |

## Verification
On every cycle, the checker confirms the following: the enables never overlap, shutdown codes clear both enables, each turn-on agrees with the level of the command, and no turn-on comes after fewer off cycles than the shortest preset. The exact gap length for each preset, the latching of the preset at the start of a gap, the restart on a re-toggle, and the full wait after reset or shutdown are visible only through the bench's scenarios. In those scenarios, the scoreboard predicts every cycle of both enables.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_GAP = 2'd1,
    ST_ON  = 2'd2
  } gpdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startGap;   // release both sides, latch side and preset
    logic countDown;  // advance the gap counter
    logic turnOn;     // assert the latched side
    logic forceOff;   // shutdown: clear both sides
  } gpdStrobe_t;

endpackage

// File: rtl/gpd_datapath.sv
module gpd_datapath
  import gpd_pkg::*;
#(
  parameter int unsigned TICKS_DT0 = 3,
  parameter int unsigned TICKS_DT1 = 5,
  parameter int unsigned TICKS_DT2 = 7,
  parameter int unsigned TICKS_DT3 = 9,
  parameter int unsigned MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swIn,
  input  logic [MODE_W-1:0] modeCode,
  input  gpdStrobe_t        strobe,
  output logic              shutReq,
  output logic              inputMoved,
  output logic              cntDone,
  output logic              hiEn,
  output logic              loEn
);

  localparam int unsigned NUM_PRESETS = 4;
  localparam int unsigned SEL_W       = $clog2(NUM_PRESETS);
  localparam int unsigned MAX_A       = (TICKS_DT0 > TICKS_DT1) ? TICKS_DT0 : TICKS_DT1;
  localparam int unsigned MAX_B       = (TICKS_DT2 > TICKS_DT3) ? TICKS_DT2 : TICKS_DT3;
  localparam int unsigned MAX_TICKS   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W       = $clog2(MAX_TICKS + 1);
  localparam int unsigned TICK_TAB [NUM_PRESETS] = '{TICKS_DT0, TICKS_DT1, TICKS_DT2, TICKS_DT3};

  logic [CNT_W-1:0] presetLoad [NUM_PRESETS];
  logic [CNT_W-1:0] gapCnt;
  logic             tgtSide;

  // counter load value per preset: ticks minus one, so zero marks the turn-on edge
  for (genvar i = 0; i < NUM_PRESETS; i++) begin : g_preset
    assign presetLoad[i] = CNT_W'(TICK_TAB[i] - 1);
  end

  // any code above the preset range means shutdown
  assign shutReq    = |modeCode[MODE_W-1:SEL_W];
  assign inputMoved = (swIn != tgtSide);
  assign cntDone    = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      tgtSide <= 1'b0;
    end else if (strobe.startGap) begin
      gapCnt  <= presetLoad[modeCode[SEL_W-1:0]];
      tgtSide <= swIn;
    end else if (strobe.countDown) begin
      gapCnt  <= gapCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiEn <= 1'b0;
      loEn <= 1'b0;
    end else if (strobe.forceOff || strobe.startGap) begin
      hiEn <= 1'b0;
      loEn <= 1'b0;
    end else if (strobe.turnOn) begin
      hiEn <= tgtSide;
      loEn <= ~tgtSide;
    end
  end

endmodule

// File: rtl/gpd_ctrl.sv
module gpd_ctrl
  import gpd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       shutReq,
  input  logic       inputMoved,
  input  logic       cntDone,
  output gpdStrobe_t strobe
);

  gpdState_e stateQ;
  gpdState_e stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    if (shutReq) begin
      strobe.forceOff = 1'b1;
      stateD          = ST_OFF;
    end else begin
      unique case (stateQ)
        ST_OFF: begin
          strobe.startGap = 1'b1;
          stateD          = ST_GAP;
        end
        ST_GAP: begin
          if (inputMoved) begin
            strobe.startGap = 1'b1;
          end else if (cntDone) begin
            strobe.turnOn = 1'b1;
            stateD        = ST_ON;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        ST_ON: begin
          if (inputMoved) begin
            strobe.startGap = 1'b1;
            stateD          = ST_GAP;
          end
        end
        default: begin
          strobe.forceOff = 1'b1;
          stateD          = ST_OFF;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/gate_pair_deadtime.sv
module gate_pair_deadtime
  import gpd_pkg::*;
#(
  parameter int unsigned TICKS_DT0 = 3,
  parameter int unsigned TICKS_DT1 = 5,
  parameter int unsigned TICKS_DT2 = 7,
  parameter int unsigned TICKS_DT3 = 9,
  parameter int unsigned MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swIn,
  input  logic [MODE_W-1:0] modeCode,
  output logic              hiEn,
  output logic              loEn
);

  gpdStrobe_t strobe;
  logic       shutReq;
  logic       inputMoved;
  logic       cntDone;

  gpd_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .shutReq    (shutReq),
    .inputMoved (inputMoved),
    .cntDone    (cntDone),
    .strobe     (strobe)
  );

  gpd_datapath #(
    .TICKS_DT0 (TICKS_DT0),
    .TICKS_DT1 (TICKS_DT1),
    .TICKS_DT2 (TICKS_DT2),
    .TICKS_DT3 (TICKS_DT3),
    .MODE_W    (MODE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .swIn       (swIn),
    .modeCode   (modeCode),
    .strobe     (strobe),
    .shutReq    (shutReq),
    .inputMoved (inputMoved),
    .cntDone    (cntDone),
    .hiEn       (hiEn),
    .loEn       (loEn)
  );

endmodule

// File: rtl/gpd_checker.sv
module gpd_checker #(
  parameter int unsigned MIN_TICKS = 3,
  parameter int unsigned MODE_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              swIn,
  input logic [MODE_W-1:0] modeCode,
  input logic              hiEn,
  input logic              loEn
);

  // consecutive cycles with both enables low, saturating
  logic [7:0] offRun;

  always_ff @(posedge clk) begin
    if (!rstN)                offRun <= '0;
    else if (hiEn || loEn)    offRun <= '0;
    else if (offRun != 8'hFF) offRun <= offRun + 1'b1;
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hiEn && loEn));

  // R4
  shut_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode >= MODE_W'(4)) |=> (!hiEn && !loEn));

  // R1
  hi_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiEn) |-> $past(swIn));

  // R1
  lo_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loEn) |-> !$past(swIn));

  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hiEn) || $rose(loEn)) |-> (offRun >= 8'(MIN_TICKS)));

endmodule

bind gate_pair_deadtime gpd_checker #(
  .MIN_TICKS (TICKS_DT0),
  .MODE_W    (MODE_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .swIn     (swIn),
  .modeCode (modeCode),
  .hiEn     (hiEn),
  .loEn     (loEn)
);

// File: tb/gate_pair_deadtime_tb_top.sv
module gate_pair_deadtime_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swIn = 1'b0;
  logic [2:0] modeCode = 3'd0;
  logic       hiEn;
  logic       loEn;

  int checks = 0;
  int errors = 0;
  int cycNow = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gate_pair_deadtime dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .swIn     (swIn),
    .modeCode (modeCode),
    .hiEn     (hiEn),
    .loEn     (loEn)
  );

  typedef struct {
    int    cyc;
    logic  hi;
    logic  lo;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference model built from the requirements
  int   mState = 0;   // 0 idle/off, 1 gap running, 2 on
  logic mTgt   = 1'b0;
  int   mLeft  = 0;
  logic mHi    = 1'b0;
  logic mLo    = 1'b0;

  always @(posedge clk) cycNow <= cycNow + 1;

  // R3: gap length in ticks per preset code
  function automatic int ticksOf(input logic [2:0] m);
    return 3 + 2 * int'(m);
  endfunction

  task automatic step(input logic sw, input logic [2:0] mode, input string tag);
    swIn     = sw;
    modeCode = mode;
    if (mode >= 3'd4) begin
      mHi = 1'b0; mLo = 1'b0; mState = 0;
    end else if (mState == 0 || sw != mTgt) begin
      mTgt = sw; mLeft = ticksOf(mode) - 1;
      mHi = 1'b0; mLo = 1'b0; mState = 1;
    end else if (mState == 1) begin
      if (mLeft == 0) begin
        mHi = mTgt; mLo = !mTgt; mState = 2;
      end else begin
        mLeft--;
      end
    end
    expQ.push_back('{cyc: cycNow + 1, hi: mHi, lo: mLo, tag: tag});
    @(posedge clk);
    #2;
  endtask

  task automatic hold(input logic sw, input logic [2:0] mode, input int n, input string tag);
    for (int i = 0; i < n; i++) step(sw, mode, tag);
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc == cycNow) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (hiEn !== it.hi || loEn !== it.lo) begin
        errors++;
        $display("FAIL %s cyc %0d: hiEn/loEn actual %b%b expected %b%b",
                 it.tag, it.cyc, hiEn, loEn, it.hi, it.lo);
      end
    end
  end

  initial begin
    // R8: reset holds both off, even with a live command
    swIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (hiEn !== 1'b0 || loEn !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: actual %b%b expected 00", hiEn, loEn);
    end
    @(posedge clk);
    #2;
    rstN = 1'b1;
    mState = 0; mHi = 1'b0; mLo = 1'b0;

    // R6: after reset, full gap before the upper side turns on
    hold(1'b1, 3'd0, 6, "R6_reset_exit");
    // R3 / R1: each preset, both directions
    hold(1'b0, 3'd0, 6, "R3_mode0_lo");
    hold(1'b1, 3'd0, 6, "R3_mode0_hi");
    hold(1'b0, 3'd1, 8, "R3_mode1_lo");
    hold(1'b1, 3'd1, 8, "R3_mode1_hi");
    hold(1'b0, 3'd2, 10, "R3_mode2_lo");
    hold(1'b1, 3'd2, 10, "R3_mode2_hi");
    hold(1'b0, 3'd3, 12, "R3_mode3_lo");
    hold(1'b1, 3'd3, 12, "R1_mode3_hi");
    // R5: preset change while on has no effect until the next toggle
    hold(1'b1, 3'd0, 4, "R5_change_on");
    hold(1'b0, 3'd0, 6, "R5_new_preset");
    // R5: preset change during a running gap keeps the latched length
    step(1'b1, 3'd0, "R5_gap_start");
    hold(1'b1, 3'd3, 6, "R5_mid_gap");
    // R7: re-toggle during a gap restarts it for the other side
    hold(1'b0, 3'd3, 4, "R7_partial");
    hold(1'b1, 3'd3, 12, "R7_restart");
    hold(1'b0, 3'd1, 1, "R7_fast");
    hold(1'b1, 3'd1, 1, "R7_fast");
    hold(1'b0, 3'd1, 1, "R7_fast");
    hold(1'b1, 3'd1, 8, "R7_settle");
    // R4: every shutdown code, with the command toggling
    for (int c = 4; c < 8; c++) begin
      step(1'b0, 3'(c), "R4_shutdown");
      step(1'b1, 3'(c), "R4_shutdown");
      step(1'b0, 3'(c), "R4_shutdown");
    end
    // R6: leaving shutdown waits one full gap
    hold(1'b0, 3'd1, 8, "R6_shut_exit");
    // R4: shutdown in the middle of a gap
    hold(1'b1, 3'd2, 3, "R4_gap_pre");
    hold(1'b1, 3'd5, 2, "R4_gap_shut");
    hold(1'b1, 3'd2, 10, "R6_shut_exit2");
    // R2: overlap never seen across the run (also checked per cycle above)
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule